// File: doc/BRIEF.md
# RAM-to-Serial Byte Transmitter

This block keeps a small byte store, 32 entries of 8 bits by default, that a host fills through a plain write port. A one-cycle start request sends the whole store: the block reads the entries in rising address order, loads each one into a shift register and presents its bits on a single NRZ output, least significant bit first. Each bit stays on the line until a serial slot uses it. A serial slot is a clock cycle in which the serial enable input is high. In the intended system that enable comes from a divider running at one quarter of the system clock.

A downstream stage adds stuffing bits and line coding. When that stage inserts a bit of its own, it raises the stall input during the slot. The transmitter then holds the current bit for that slot and no payload bit is lost. The busy output covers the whole transfer. While busy is high, start requests and writes to the store are refused.

Top module: `ramser_tx`

## Requirements
- R1: After the asynchronous reset `rst_a` is released, `busy` is 0 and `sout` is at the idle level 1.
- R2: While `busy` is 0, a cycle with `wr_en` high stores `wr_data` at `wr_addr`. The next transfer sends that value in the slot position of that address.
- R3: A `start` while idle sets `busy` at the next clock edge. `busy` stays high until the clock edge of the 256th consumed slot (DEPTH*DATA_W in general) and is low from then on.
- R4: Bytes go out in address order 0, 1, ..., 31, with no gaps and no repeats.
- R5: Within a byte, bit 0 is sent first and bit 7 last. Each bit is what `sout` shows in the cycle of the consumed slot that takes it.
- R6: A slot with `stall` high consumes no bit. `sout` and the byte position do not change across it.
- R7: A `start` while `busy` is 1 has no effect. The running transfer keeps its length and content.
- R8: A write while `busy` is 1 is refused. The addressed entry keeps its old value, which the next transfer shows.
- R9: While busy, `sout` does not change in a cycle whose `ser_en` is low.
- R10: While `busy` is 0, `sout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_a | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Write strobe for the byte store |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| start | input | 1 | Begin a transfer of the whole store |
| ser_en | input | 1 | Serial slot strobe, one cycle in four |
| stall | input | 1 | Downstream inserted a bit; skip this slot |
| sout | output | 1 | NRZ serial data, idle high |
| busy | output | 1 | Transfer in progress |

## Verification
The bench sweeps every address with several data patterns, including runs of all ones and all zeros, under four stall patterns. These cover isolated stalls, consecutive stalls and stalls that fall on byte boundaries.

- A design that shifts even when stalled loses a bit in each affected byte.
- A design that mishandles the last bit of a byte repeats or skips a byte, which changes the count of consumed slots before `busy` falls.
- A design that honours a start or a write during a transfer restarts the stream early, or corrupts entry 5. The run that follows exposes it.
- A design that sends bits MSB first returns mirrored bytes.

// File: rtl/ramser_pkg.sv
package ramser_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } ramser_state_t;

   function automatic int unsigned ramser_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ramser_mem.sv
module ramser_mem #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[wr_addr] <= wr_data;
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/ramser_shifter.sv
module ramser_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter bit          IDLE_LVL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_a,
   input  logic              active,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   output logic              last_bit,
   output logic              bit_out
);
   import ramser_pkg::*;
   localparam int unsigned CNT_W = ramser_cnt_w(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sreg;
   logic [DATA_W-1:0] sreg_next;
   logic [CNT_W-1:0]  bcnt;
   logic              head;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign head      = sreg[0];
         assign sreg_next = {1'b0, sreg[DATA_W-1:1]};
      end else begin : g_msb
         assign head      = sreg[DATA_W-1];
         assign sreg_next = {sreg[DATA_W-2:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a) begin
         sreg <= '0;
         bcnt <= '0;
      end else if (load) begin
         sreg <= load_data;
         bcnt <= '0;
      end else if (shift) begin
         sreg <= sreg_next;
         bcnt <= bcnt + 1'b1;
      end
   end

   assign last_bit = (bcnt == CNT_LAST);
   assign bit_out  = active ? head : IDLE_LVL;
endmodule

// File: rtl/ramser_ctrl.sv
module ramser_ctrl #(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_a,
   input  logic              start,
   input  logic              ser_en,
   input  logic              stall,
   input  logic              last_bit,
   input  logic              wr_req,
   output logic              wr_ok,
   output logic              load,
   output logic              shift,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy
);
   import ramser_pkg::*;
   localparam logic [ADDR_W-1:0] IDX_LAST = {ADDR_W{1'b1}};

   ramser_state_t     state;
   ramser_state_t     state_nx;
   logic [ADDR_W-1:0] idx;
   logic [ADDR_W-1:0] idx_nx;
   logic              advance;

   assign busy    = (state == ST_SEND);
   assign advance = busy && ser_en && !stall;
   assign wr_ok   = wr_req && !busy;
   assign rd_addr = busy ? idx + 1'b1 : '0;

   always_comb begin
      state_nx = state;
      idx_nx   = idx;
      load     = 1'b0;
      shift    = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               load     = 1'b1;
               idx_nx   = '0;
               state_nx = ST_SEND;
            end
         end
         ST_SEND: begin
            if (advance) begin
               if (!last_bit) begin
                  shift = 1'b1;
               end else if (idx == IDX_LAST) begin
                  state_nx = ST_IDLE;
               end else begin
                  load   = 1'b1;
                  idx_nx = idx + 1'b1;
               end
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         state <= state_nx;
         idx   <= idx_nx;
      end
   end
endmodule

// File: rtl/ramser_tx.sv
module ramser_tx #(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b1,
   parameter bit          IDLE_LVL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_a,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start,
   input  logic              ser_en,
   input  logic              stall,
   output logic              sout,
   output logic              busy
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ramser_tx: DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
         $error("ramser_tx: ADDR_W must be in 1..10");
      end
   endgenerate

   logic              wr_ok;
   logic              load;
   logic              shift;
   logic              last_bit;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;

   ramser_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk      (clk),
      .rst_a    (rst_a),
      .start    (start),
      .ser_en   (ser_en),
      .stall    (stall),
      .last_bit (last_bit),
      .wr_req   (wr_en),
      .wr_ok    (wr_ok),
      .load     (load),
      .shift    (shift),
      .rd_addr  (rd_addr),
      .busy     (busy)
   );

   ramser_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk     (clk),
      .wr_en   (wr_ok),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   ramser_shifter #(
      .DATA_W    (DATA_W),
      .LSB_FIRST (LSB_FIRST),
      .IDLE_LVL  (IDLE_LVL)
   ) u_shift (
      .clk       (clk),
      .rst_a     (rst_a),
      .active    (busy),
      .load      (load),
      .load_data (rd_data),
      .shift     (shift),
      .last_bit  (last_bit),
      .bit_out   (sout)
   );
endmodule

// File: rtl/ramser_tx_chk.sv
module ramser_tx_chk #(
   parameter bit IDLE_LVL = 1'b1
) (
   input logic clk,
   input logic rst_a,
   input logic start,
   input logic ser_en,
   input logic stall,
   input logic sout,
   input logic busy
);
   p_busy_rise_r3: assert property (@(posedge clk) disable iff (rst_a)
      (!busy && start) |=> busy);

   p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst_a)
      (busy && !(ser_en && !stall)) |=> busy);

   p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst_a)
      (busy && ser_en && stall) |=> $stable(sout));

   p_hold_noen_r9: assert property (@(posedge clk) disable iff (rst_a)
      (busy && !ser_en) |=> $stable(sout));

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst_a)
      (busy && start && !ser_en) |=> (busy && $stable(sout)));

   p_idle_level_r10: assert property (@(posedge clk) disable iff (rst_a)
      !busy |-> (sout == IDLE_LVL));
endmodule

bind ramser_tx ramser_tx_chk #(.IDLE_LVL(IDLE_LVL)) u_chk (
   .clk    (clk),
   .rst_a  (rst_a),
   .start  (start),
   .ser_en (ser_en),
   .stall  (stall),
   .sout   (sout),
   .busy   (busy)
);

// File: tb/ramser_tx_tb_top.sv
module ramser_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NBITS  = DEPTH * DATA_W;

   logic              clk = 1'b0;
   logic              rst_a = 1'b1;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              start = 1'b0;
   logic              ser_en = 1'b0;
   logic              stall = 1'b0;
   logic              sout;
   logic              busy;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int div = 0;
   logic [DATA_W-1:0] model [DEPTH];
   logic [NBITS-1:0]  rx;

   always #(CLK_PERIOD/2) clk = ~clk;

   ramser_tx dut_i (
      .clk(clk), .rst_a(rst_a), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .ser_en(ser_en), .stall(stall),
      .sout(sout), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic next_en();
      ser_en = (div == 3);
      div = (div + 1) % 4;
   endtask

   function automatic bit stall_of(input int mode, input int s);
      case (mode)
         1: return (s % 3) == 2;
         2: return (s % 8) < 3;
         3: return ((s * 5 + 1) % 7) == 0;
         default: return 1'b0;
      endcase
   endfunction

   task automatic write_word(input int a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      next_en();
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
      model[a] = d;
      @(negedge clk);
      next_en();
      wr_en = 1'b0;
   endtask

   task automatic load_pattern(input int p);
      for (int i = 0; i < DEPTH; i++) begin
         logic [DATA_W-1:0] d;
         case (p)
            0: d = DATA_W'(i * 37 + 5);
            1: d = (i % 2 == 0) ? 8'hFF : 8'h00;
            default: d = DATA_W'({i[4:0], 3'b101}) ^ 8'hA5;
         endcase
         write_word(i, d);
      end
   endtask

   task automatic run_tx(input int mode, input bit inject);
      int nbits = 0;
      int slot = 0;
      int cyc = 0;
      int hold_bad_en = 0;
      int hold_bad_st = 0;
      int byte_bad = 0;
      bit prev_adv = 1'b1;
      bit prev_stall = 1'b0;
      logic prev_sout = 1'b1;
      rx = '0;
      @(negedge clk);
      next_en();
      start = 1'b1; stall = 1'b0;
      @(negedge clk);
      start = 1'b0;
      // R3: busy set by the edge following the start cycle
      check(busy == 1'b1, "R3 busy rise", busy, 1);
      prev_sout = sout;
      forever begin
         bit cur_stall;
         if (cyc > 0) @(negedge clk);
         cyc++;
         if (cyc > 4 * NBITS * 3) begin
            check(1'b0, "R3 run length", cyc, 4 * NBITS);
            break;
         end
         if (!busy) break;
         // R9 / R6: no change without a consumed slot
         if (cyc > 1 && !prev_adv) begin
            if (sout !== prev_sout) begin
               if (prev_stall) hold_bad_st++;
               else hold_bad_en++;
            end
         end
         wr_en = 1'b0; start = 1'b0;
         if (inject && cyc == 200) begin
            wr_en = 1'b1; wr_addr = 5; wr_data = ~model[5]; // R8
         end
         if (inject && cyc == 401) start = 1'b1;             // R7
         next_en();
         cur_stall = ser_en ? stall_of(mode, slot) : 1'b0;
         stall = cur_stall;
         if (ser_en) slot++;
         prev_adv = ser_en && !cur_stall;
         prev_stall = ser_en && cur_stall;
         prev_sout = sout;
         if (prev_adv) begin
            if (nbits < NBITS) rx[nbits] = sout;
            nbits++;
         end
      end
      wr_en = 1'b0; start = 1'b0; stall = 1'b0;
      check(nbits == NBITS, "R3 consumed slots before busy fall", nbits, NBITS);
      check(hold_bad_en == 0, "R9 hold without enable", hold_bad_en, 0);
      check(hold_bad_st == 0, "R6 hold on stalled slot", hold_bad_st, 0);
      for (int b = 0; b < DEPTH; b++) begin
         logic [DATA_W-1:0] got;
         got = rx[b*DATA_W +: DATA_W];
         if (got !== model[b]) begin
            byte_bad++;
            // R4 R5 order and bit sequence; R2 content
            check(1'b0, "R4 R5 byte content", int'(got), int'(model[b]));
         end
      end
      check(byte_bad == 0, "R2 R4 R5 all bytes", byte_bad, 0);
      if (inject) check(nbits == NBITS, "R7 start while busy", nbits, NBITS);
      check(sout == 1'b1, "R10 idle level after transfer", sout, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy in reset", busy, 0);
      check(sout == 1'b1, "R1 sout in reset", sout, 1);
      rst_a = 1'b0;
      @(negedge clk);
      check(busy == 1'b0 && sout == 1'b1, "R1 after release", {busy, sout}, 1);
      load_pattern(0);
      run_tx(0, 1'b0);
      run_tx(1, 1'b1);
      run_tx(2, 1'b0);   // R8: entry 5 must still hold its old value
      load_pattern(1);
      run_tx(3, 1'b0);
      load_pattern(2);
      run_tx(2, 1'b0);
      run_tx(0, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule